// File: doc/BRIEF.md
# DMA Sample Hold and Stop Controller

This block sits between DMA read channels and the sinks that consume their samples. Each channel registers every sample the DMA delivers while its enable is high, and presents that sample to the sink. When the channel is halted or masked, the enable toward the DMA drops, no further samples are taken, and the sink keeps seeing the last accepted sample for as long as the halt lasts. This works the same for single-shot and cyclic transfers, because the block only watches the valid strobe.

A channel halts when software raises its stop bit or when the shared external trigger shows a rising edge while that channel's trigger enable is set. The trigger is synchronised through two flops before its edge is taken. In lock-step mode the stop requests of all channels are ORed, so every channel halts on the same clock edge. A halt is sticky. It is released by a rearm pulse once the stop request is gone. The mask bit removes the enable on its own, whether or not the channel is halted.

Top module: `dma_hold_ctrl`

## Requirements
- R1: While `rst_n` is low, every `dma_en` bit is 0 and every held sample is 0.
- R2: If `mask[c]` is 1 at a clock edge, `dma_en[c]` is 0 after that edge, whatever the stop state.
- R3: If `dma_en[c]` and `src_valid[c]` are both 1 at an edge, channel c's slice of `hold_data` (bits c*DATA_W up to c*DATA_W+DATA_W-1) equals the sampled `src_data` slice after that edge.
- R4: If `dma_en[c]` is 0 at an edge, the held sample of channel c does not change, even when `src_valid[c]` is 1.
- R5: If `sw_stop[c]` is 1 at an edge, channel c is halted and `dma_en[c]` is 0 after that edge. The halt stays after `sw_stop[c]` falls.
- R6: A rising edge on `trig_in` halts every channel with `trig_en` set. With `trig_in` rising between edges, `dma_en` is still 1 after the first and second edges and is 0 after the third. A `trig_in` that stays high does not halt the channel again after a rearm.
- R7: A channel with `trig_en[c]` at 0 ignores the trigger.
- R8: With `sync_en` at 1, a stop request from any channel (software or trigger) halts all channels on the same edge.
- R9: With `sync_en` at 0, a stop request halts only its own channel.
- R10: A `rearm[c]` pulse with `sw_stop[c]` and `mask[c]` both 0, and no trigger stop in that cycle, makes `dma_en[c]` 1 after that edge. New samples are then captured again.
- R11: A sample that is valid on the same edge as a stop request, while the enable is still high, is captured and then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous external stop trigger |
| sync_en | input | 1 | Lock-step stop across all channels |
| trig_en | input | NUM_CH | Per-channel trigger enable |
| mask | input | NUM_CH | Per-channel DMA enable mask |
| sw_stop | input | NUM_CH | Per-channel software stop request (level) |
| rearm | input | NUM_CH | Per-channel halt release pulse |
| src_valid | input | NUM_CH | Per-channel DMA sample valid |
| src_data | input | NUM_CH*DATA_W | DMA samples, channel c in slice c |
| dma_en | output | NUM_CH | Enable toward each DMA channel |
| hold_data | output | NUM_CH*DATA_W | Held samples toward the sinks, channel c in slice c |

## Verification
A halt flag stuck in the wrong state shows on `dma_en` after one edge, while a stop, rearm or mask is applied. A wrong capture condition shows on `hold_data` one edge after any valid strobe, as a changed value where a frozen one was expected, or the reverse. A fault in the synchroniser or the edge detector moves the drop of `dma_en` away from the third edge after the trigger rises, or makes a trigger held high halt a rearmed channel again. Both are visible within four cycles. The bench sweeps a pseudo-random mix of control bits and compares every output on every cycle.

// File: rtl/dhc_pkg.sv
// Package: shared types for the DMA hold/stop controller.
// Assumes: imported by every module of the block.
package dhc_pkg;
    // Halt state of one channel.
    typedef enum logic {
        CH_RUN  = 1'b0,
        CH_HALT = 1'b1
    } ch_state_t;
endpackage

// File: rtl/dhc_trig_sync.sv
// Module: dhc_trig_sync
// Brings an asynchronous trigger into the clock domain through STAGES
// flops and emits a one-cycle pulse on each synchronised rising edge.
// Assumes: the trigger stays high or low for at least two clock cycles.
module dhc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift chain for metastability settling, plus a copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // The rising edge is a new high on the last stage.
    always_comb rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dhc_stop_ctrl.sv
// Module: dhc_stop_ctrl
// Keeps the sticky halt state of every channel and produces the registered
// enable toward each DMA. In lock-step mode every channel's stop request is
// applied to all channels.
// Assumes: stop_req is already qualified by the trigger enables.
module dhc_stop_ctrl
    import dhc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [NUM_CH-1:0] stop_req,
    input  logic [NUM_CH-1:0] rearm,
    input  logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] en_o
);
    logic              any_stop;
    logic [NUM_CH-1:0] eff_stop;

    // OR of every channel's request, used in lock-step mode.
    always_comb any_stop = |stop_req;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_state_t state_q;
        ch_state_t state_d;

        // Pick the lock-step or the independent stop for this channel.
        always_comb eff_stop[c] = sync_en ? any_stop : stop_req[c];

        // A stop wins over a rearm; otherwise a rearm releases the halt.
        always_comb begin
            if (eff_stop[c])
                state_d = CH_HALT;
            else if (rearm[c])
                state_d = CH_RUN;
            else
                state_d = state_q;
        end

        // Halt register and registered enable; the mask gates the enable only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= CH_RUN;
                en_o[c] <= 1'b0;
            end else begin
                state_q <= state_d;
                en_o[c] <= ~mask[c] & (state_d == CH_RUN);
            end
        end
    end
endmodule

// File: rtl/dhc_hold_reg.sv
// Module: dhc_hold_reg
// Takes a sample when the DMA presents one while enabled, and otherwise
// keeps the last sample for the sink with no time limit.
// Assumes: en is the enable currently driven toward the DMA.
module dhc_hold_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] hold_o
);
    // Capture on an accepted sample, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_o <= '0;
        else if (en && valid)
            hold_o <= data;
    end
endmodule

// File: rtl/dma_hold_ctrl.sv
// Module: dma_hold_ctrl (top)
// Per-channel sample hold and stop controller between DMA channels and sinks.
// Combines software stops and a synchronised trigger edge into the stop
// requests, keeps the halt state, and freezes each sink on its last sample.
// Assumes: trig_in is asynchronous; all other inputs are synchronous to clk.
module dma_hold_ctrl #(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_in,
    input  logic                     sync_en,
    input  logic [NUM_CH-1:0]        trig_en,
    input  logic [NUM_CH-1:0]        mask,
    input  logic [NUM_CH-1:0]        sw_stop,
    input  logic [NUM_CH-1:0]        rearm,
    input  logic [NUM_CH-1:0]        src_valid,
    input  logic [NUM_CH*DATA_W-1:0] src_data,
    output logic [NUM_CH-1:0]        dma_en,
    output logic [NUM_CH*DATA_W-1:0] hold_data
);
    logic              trig_rise;
    logic [NUM_CH-1:0] stop_req;

    // Trigger synchroniser and edge detector.
    dhc_trig_sync #(.STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise_o   (trig_rise)
    );

    // Software stop, or trigger edge on channels that listen to it.
    always_comb stop_req = sw_stop | (trig_en & {NUM_CH{trig_rise}});

    dhc_stop_ctrl #(.NUM_CH(NUM_CH)) u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .stop_req (stop_req),
        .rearm    (rearm),
        .mask     (mask),
        .en_o     (dma_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
        dhc_hold_reg #(.DATA_W(DATA_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (dma_en[c]),
            .valid  (src_valid[c]),
            .data   (src_data[c*DATA_W +: DATA_W]),
            .hold_o (hold_data[c*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/dma_hold_ctrl_chk.sv
// Module: dma_hold_ctrl_chk
// Port-level properties of dma_hold_ctrl, attached with bind.
// Assumes: the same parameters as the bound instance.
module dma_hold_ctrl_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sync_en,
    input logic [NUM_CH-1:0]        mask,
    input logic [NUM_CH-1:0]        sw_stop,
    input logic [NUM_CH-1:0]        src_valid,
    input logic [NUM_CH*DATA_W-1:0] src_data,
    input logic [NUM_CH-1:0]        dma_en,
    input logic [NUM_CH*DATA_W-1:0] hold_data
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: a mask on the previous edge forces the enable low.
        assert_mask_gates_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mask[c])) |-> !dma_en[c]);

        // R3: an accepted sample appears on the held output.
        assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dma_en[c] && src_valid[c]))
            |-> hold_data[c*DATA_W +: DATA_W] == $past(src_data[c*DATA_W +: DATA_W]));

        // R4: without an enable the held sample does not move.
        assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(dma_en[c]))
            |-> $stable(hold_data[c*DATA_W +: DATA_W]));

        // R5: a software stop removes the enable on the next edge.
        assert_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sw_stop[c])) |-> !dma_en[c]);

        // R8: in lock-step mode any channel's stop removes every enable.
        assert_sync_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sync_en) && $past(|sw_stop)) |-> !dma_en[c]);
    end
endmodule

bind dma_hold_ctrl dma_hold_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_en   (sync_en),
    .mask      (mask),
    .sw_stop   (sw_stop),
    .src_valid (src_valid),
    .src_data  (src_data),
    .dma_en    (dma_en),
    .hold_data (hold_data)
);

// File: tb/dma_hold_ctrl_bench.sv
module dma_hold_ctrl_bench;
    localparam int NCH = 2;
    localparam int DW = 8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic sync_en = 1'b0;
    logic [NCH-1:0] trig_en = '0, mask = '0, sw_stop = '0, rearm = '0, src_valid = '0;
    logic [NCH*DW-1:0] src_data = '0;
    logic [NCH-1:0] dma_en;
    logic [NCH*DW-1:0] hold_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected state, from the requirements.
    logic [NCH-1:0] m_halt = '0, m_en = '0;
    logic [DW-1:0] m_data [NCH];
    logic m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_hold_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) u_dma_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sync_en(sync_en),
        .trig_en(trig_en), .mask(mask), .sw_stop(sw_stop), .rearm(rearm),
        .src_valid(src_valid), .src_data(src_data),
        .dma_en(dma_en), .hold_data(hold_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock with the inputs already applied; model, then compare.
    task automatic step(input string tag);
        logic rise;
        logic any_stop;
        logic [NCH-1:0] stop_c, eff, halt_n, en_n, acc;
        logic [DW-1:0] data_n [NCH];
        string te, td;
        rise = m_s2 & ~m_s3;
        stop_c = sw_stop | (trig_en & {NCH{rise}});
        any_stop = |stop_c;
        for (int c = 0; c < NCH; c++) begin
            eff[c] = sync_en ? any_stop : stop_c[c];
            halt_n[c] = eff[c] | (m_halt[c] & ~rearm[c]);
            en_n[c] = ~mask[c] & ~halt_n[c];
            acc[c] = m_en[c] & src_valid[c];
            data_n[c] = acc[c] ? src_data[c*DW +: DW] : m_data[c];
        end
        @(posedge clk);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
        m_halt = halt_n; m_en = en_n;
        for (int c = 0; c < NCH; c++) m_data[c] = data_n[c];
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (tag != "") begin
                te = tag; td = tag;
            end else begin
                te = mask[c] ? "R2" : (sync_en && any_stop) ? "R8" : stop_c[c] ? "R5" : "R10";
                td = acc[c] ? "R3" : "R4";
            end
            check({te, " dma_en"}, 32'(dma_en[c]), 32'(m_en[c]));
            check({td, " hold_data"}, 32'(hold_data[c*DW +: DW]), 32'(m_data[c]));
        end
    endtask

    task automatic quiet();
        mask = '0; sw_stop = '0; rearm = '0; src_valid = '0; trig_en = '0; sync_en = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) m_data[c] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        check("R1 dma_en", 32'(dma_en), 32'h0);
        check("R1 hold_data", 32'(hold_data), 32'h0);
        rst_n = 1'b1;
        step("R10");

        // Pseudo-random sweep over stops, masks, rearms, sync and data.
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mask      = {lfsr[0] & lfsr[5] & lfsr[9], lfsr[1] & lfsr[6] & lfsr[11]};
            sw_stop   = {lfsr[2] & lfsr[7] & lfsr[14], lfsr[3] & lfsr[8] & lfsr[13]};
            rearm     = {lfsr[4] | lfsr[10], lfsr[12] | lfsr[15]};
            sync_en   = lfsr[9] ^ lfsr[3];
            src_valid = {lfsr[11], lfsr[6] | lfsr[1]};
            src_data  = {lfsr[7:0], lfsr[15:8]} ^ 16'(i);
            step("");
        end

        // R11: sample valid on the stop edge is still captured, then held.
        quiet(); rearm = '1; step("R10");
        rearm = '0; sw_stop = 2'b01; src_valid = 2'b01; src_data = 16'h00A5;
        step("R11");
        sw_stop = '0; src_data = 16'h005A;
        step("R11");
        repeat (3) step("R4");

        // R9: independent stop leaves the other channel running.
        quiet(); rearm = '1; step("R10");
        rearm = '0; sw_stop = 2'b10; src_valid = 2'b11; src_data = 16'h1234;
        step("R9");
        sw_stop = '0; src_data = 16'h4321; step("R9");

        // R6/R7: trigger edge halts channel 0 only, on the third edge.
        quiet(); rearm = '1; step("R10");
        rearm = '0; trig_en = 2'b01; src_valid = 2'b11;
        trig_in = 1'b1;
        step("R6"); step("R6"); step("R6");
        check("R6 ch0 halted", 32'(dma_en[0]), 32'h0);
        check("R7 ch1 running", 32'(dma_en[1]), 32'h1);
        rearm = 2'b01; step("R6");
        rearm = '0; repeat (4) step("R6");
        check("R6 no retrigger while high", 32'(dma_en[0]), 32'h1);
        trig_in = 1'b0; repeat (3) step("R7");

        // R8: trigger on channel 1 with lock-step halts both.
        trig_en = 2'b10; sync_en = 1'b1; trig_in = 1'b1;
        repeat (3) step("R8");
        check("R8 both halted", 32'(dma_en), 32'h0);
        trig_in = 1'b0; quiet(); rearm = '1; step("R10");
        rearm = '0; src_valid = 2'b11; src_data = 16'hBEEF; step("R10");
        step("R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule